// File: doc/BRIEF.md
# Rotating Per-Line Error Rate Counter

This block takes eight single-cycle error pulse lines from a bit-stream checker, one line per bit lane, and counts the pulses of one lane at a time with a single shared counter. A multiplexer picks the lane. On each frame boundary the running count is copied into a holding register together with the index of the lane it belongs to. The running counter then restarts and the selection steps to the next lane. Over eight frames every lane is sampled once, and then the rotation starts again.

A host reads the held count and its lane index once per frame, after the boundary. The host turns these into error rates and keeps the running totals. The counts are only meaningful while the checker produces momentary pulses. For that reason a mode input stops counting while the checker latches its errors instead. A synchronous clear input returns the block to lane 0 with every count at zero.

Top module: `err_line_rotator`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `hold_cnt_o`, `hold_line_o` and `cur_line_o` are all zero.
- R2: Only the line whose index equals `cur_line_o` adds to the running count. Pulses on the other seven lines never change a held count.
- R3: When `frame_i` is high at a clock edge and `clr_i` is low, `hold_cnt_o` takes the number of cycles, since the previous boundary, clear or reset, in which the selected line was high. It is visible from the next cycle. Cycles at that earlier boundary itself count only as R7 describes.
- R4: At the same edge, `hold_line_o` takes the index of the line that was selected. `cur_line_o` then advances by one in the order 0,1,...,7 and wraps from 7 back to 0.
- R5: The running count is 16 bits wide and stops at 65535 instead of wrapping.
- R6: While `pulse_mode_i` is low (the checker is in latched mode), no pulse is counted. The count held at the next boundary then covers only cycles in which `pulse_mode_i` was high.
- R7: A pulse that arrives in the same cycle as a frame boundary is counted for the newly selected line. This is line `cur_line_o + 1` (mod 8). The new running count starts at 1 if that bit is high and `pulse_mode_i` is high, and at 0 otherwise.
- R8: `clr_i` high at a clock edge sets the running count, `hold_cnt_o`, `hold_line_o` and `cur_line_o` to zero. It takes priority over `frame_i`.
- R9: Between boundaries, `hold_cnt_o` and `hold_line_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of counts and line index |
| pulse_mode_i | input | 1 | High when the checker emits momentary pulses; enables counting |
| frame_i | input | 1 | Frame boundary strobe, one cycle |
| err_i | input | 8 | Error pulse lines, bit n is lane n |
| cur_line_o | output | 3 | Lane currently being counted |
| hold_cnt_o | output | 16 | Count captured at the last boundary |
| hold_line_o | output | 3 | Lane the held count belongs to |

## Verification
The bench checks an error pulse that lands on a boundary cycle. A design that counts it against the outgoing lane shows a held count one too high, and the next lane's count comes out one too low. It runs one frame of more than 65535 counted cycles. A wrapping counter would report a small number instead of 65535. It drives every lane except the selected one and asserts clear and frame together. This catches a multiplexer that picks the wrong lane, and a clear that lets the frame step still advance the line index. It also gates counting with the mode input to catch a counter that ignores latched mode. A random run over several full rotations with irregular frame lengths checks wrap-around from lane 7 to lane 0.

// File: rtl/err_rot_pkg.sv
package err_rot_pkg;
  localparam int unsigned DEF_LINES = 8;
  localparam int unsigned DEF_CNT_W = 16;

  typedef enum logic [1:0] {
    CNT_ACT_HOLD    = 2'd0,
    CNT_ACT_INC     = 2'd1,
    CNT_ACT_RESTART = 2'd2,
    CNT_ACT_ZERO    = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/err_line_mux.sv
module err_line_mux #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LINES),
  localparam int unsigned PAD_N = 1 << IDX_W
) (
  input  logic [NUM_LINES-1:0] err_i,
  input  logic [IDX_W-1:0]     sel_i,
  output logic                 bit_o
);
  logic [PAD_N-1:0] padded;

  generate
    if (PAD_N == NUM_LINES) begin : g_exact
      assign padded = err_i;
    end else begin : g_pad
      assign padded = {{(PAD_N-NUM_LINES){1'b0}}, err_i};
    end
  endgenerate

  assign bit_o = padded[sel_i];
endmodule

// File: rtl/line_rotator.sv
module line_rotator #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] sel_o,
  output logic [IDX_W-1:0] next_sel_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

  logic [IDX_W-1:0] sel_q, sel_d;

  always_comb begin
    next_sel_o = (sel_q == LAST) ? '0 : sel_q + IDX_W'(1);
    sel_d      = sel_q;
    if (clr_i)      sel_d = '0;
    else if (adv_i) sel_d = next_sel_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= LAST); // R4
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i) |=> (sel_q == (($past(sel_q) == LAST) ? '0 : $past(sel_q) + IDX_W'(1)))); // R4
  AST_SEL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(sel_q)); // R4
endmodule

// File: rtl/sat_counter.sv
module sat_counter
  import err_rot_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_i,
  input  logic             restart_i,
  input  logic             first_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_act_e         act;

  always_comb begin
    if (zero_i)                          act = CNT_ACT_ZERO;
    else if (restart_i)                  act = CNT_ACT_RESTART;
    else if (inc_i && (cnt_q != CNT_MAX)) act = CNT_ACT_INC;
    else                                 act = CNT_ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      CNT_ACT_ZERO:    cnt_d = '0;
      CNT_ACT_RESTART: cnt_d = {{(CNT_W-1){1'b0}}, first_i};
      CNT_ACT_INC:     cnt_d = cnt_q + CNT_W'(1);
      default:         cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !zero_i && !restart_i) |=> (cnt_q == CNT_MAX)); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !zero_i && !restart_i) |=> $stable(cnt_q)); // R6
  AST_RESTART_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !zero_i) |=> (cnt_q <= CNT_W'(1))); // R7
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (clr_i) begin
      cnt_d = '0;
      idx_d = '0;
    end else if (cap_i) begin
      cnt_d = cnt_i;
      idx_d = idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign cnt_o = cnt_q;
  assign idx_o = idx_q;

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && !clr_i) |=> ($stable(cnt_q) && $stable(idx_q))); // R9
endmodule

// File: rtl/err_line_rotator.sv
module err_line_rotator
  import err_rot_pkg::*;
#(
  parameter int unsigned NUM_LINES = DEF_LINES,
  parameter int unsigned CNT_W = DEF_CNT_W,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 pulse_mode_i,
  input  logic                 frame_i,
  input  logic [NUM_LINES-1:0] err_i,
  output logic [IDX_W-1:0]     cur_line_o,
  output logic [CNT_W-1:0]     hold_cnt_o,
  output logic [IDX_W-1:0]     hold_line_o
);
  logic [IDX_W-1:0] sel, next_sel;
  logic             cur_bit, next_bit;
  logic             boundary;
  logic [CNT_W-1:0] run_cnt;

  assign boundary = frame_i && !clr_i;

  line_rotator #(.NUM_LINES(NUM_LINES)) u_rot (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(boundary),
    .sel_o(sel), .next_sel_o(next_sel)
  );

  err_line_mux #(.NUM_LINES(NUM_LINES)) u_mux_cur (
    .err_i(err_i), .sel_i(sel), .bit_o(cur_bit)
  );

  err_line_mux #(.NUM_LINES(NUM_LINES)) u_mux_next (
    .err_i(err_i), .sel_i(next_sel), .bit_o(next_bit)
  );

  sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .zero_i(clr_i), .restart_i(boundary),
    .first_i(next_bit && pulse_mode_i), .inc_i(cur_bit && pulse_mode_i),
    .cnt_o(run_cnt)
  );

  hold_reg #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cap_i(boundary),
    .cnt_i(run_cnt), .idx_i(sel), .cnt_o(hold_cnt_o), .idx_o(hold_line_o)
  );

  assign cur_line_o = sel;

  AST_SNAP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (hold_cnt_o == $past(run_cnt))); // R3
  AST_SNAP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (hold_line_o == $past(cur_line_o))); // R4
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (run_cnt == '0 && hold_cnt_o == '0 && hold_line_o == '0 && cur_line_o == '0)); // R8
  AST_LATCHED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode_i && !clr_i && !frame_i) |=> $stable(run_cnt)); // R6
  AST_EDGE_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (run_cnt == CNT_W'($past(next_bit && pulse_mode_i)))); // R7
endmodule

// File: tb/err_line_rotator_bench.sv
`timescale 1ns/1ps
module err_line_rotator_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i;
  logic        pulse_mode_i;
  logic        frame_i;
  logic [7:0]  err_i;
  logic [2:0]  cur_line_o;
  logic [15:0] hold_cnt_o;
  logic [2:0]  hold_line_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int unsigned m_cnt, m_hold, m_hidx, m_sel;

  always #4 clk = ~clk;

  err_line_rotator u_err_line_rotator (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .pulse_mode_i(pulse_mode_i),
    .frame_i(frame_i), .err_i(err_i), .cur_line_o(cur_line_o),
    .hold_cnt_o(hold_cnt_o), .hold_line_o(hold_line_o)
  );

  function automatic int unsigned next_line(int unsigned s);
    return (s == 7) ? 0 : s + 1;
  endfunction

  task automatic chk(string req, int unsigned got, int unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model_edge(logic c, logic m, logic f, logic [7:0] e);
    int unsigned ns;
    if (c) begin
      m_cnt = 0; m_hold = 0; m_hidx = 0; m_sel = 0;
    end else if (f) begin
      ns = next_line(m_sel);
      m_hold = m_cnt; m_hidx = m_sel;
      m_cnt = (m && e[ns]) ? 1 : 0;
      m_sel = ns;
    end else if (m && e[m_sel] && m_cnt != 65535) begin
      m_cnt++;
    end
  endtask

  task automatic step(logic c, logic m, logic f, logic [7:0] e, bit compare);
    clr_i = c; pulse_mode_i = m; frame_i = f; err_i = e;
    @(posedge clk);
    model_edge(c, m, f, e);
    @(negedge clk);
    if (compare) begin
      chk("R3 held count", hold_cnt_o, m_hold);
      chk("R4 held line", hold_line_o, m_hidx);
      chk("R4 current line", cur_line_o, m_sel);
    end
  endtask

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; clr_i = 0; pulse_mode_i = 1; frame_i = 0; err_i = 0;
    m_cnt = 0; m_hold = 0; m_hidx = 0; m_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hold count", hold_cnt_o, 0);
    chk("R1 hold line", hold_line_o, 0);
    chk("R1 current line", cur_line_o, 0);

    // R2: all lanes but the selected one pulse
    for (int i = 0; i < 10; i++) step(0, 1, 0, 8'hFE, 0);
    step(0, 1, 1, 8'h00, 0);
    chk("R2 other lanes ignored", hold_cnt_o, 0);
    chk("R2 line index", hold_line_o, 0);

    // R3: five pulses on line 1, with noise on line 0
    for (int i = 0; i < 5; i++) step(0, 1, 0, 8'h03, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 8'h01, 0);
    step(0, 1, 1, 8'h00, 0);
    chk("R3 counted pulses", hold_cnt_o, 5);
    chk("R4 line of count", hold_line_o, 1);
    chk("R4 advanced line", cur_line_o, 2);

    // R7: boundary pulse on new line 3 credited to it
    step(0, 1, 0, 8'h04, 0);
    step(0, 1, 1, 8'h0C, 0);
    chk("R7 old line excludes edge pulse", hold_cnt_o, 1);
    step(0, 1, 1, 8'h00, 0);
    chk("R7 new line gets edge pulse", hold_cnt_o, 1);
    chk("R7 line index", hold_line_o, 3);

    // R6: latched mode, no counting (now on line 4)
    for (int i = 0; i < 6; i++) step(0, 0, 0, 8'hFF, 0);
    step(0, 1, 0, 8'h10, 0);
    step(0, 0, 1, 8'hFF, 0);
    chk("R6 latched mode ignored", hold_cnt_o, 1);
    chk("R9 line before wrap", cur_line_o, 5);

    // R4 wrap: step through lines 5,6,7 to 0
    step(0, 1, 1, 8'h00, 0);
    step(0, 1, 1, 8'h00, 0);
    step(0, 1, 1, 8'h00, 0);
    chk("R4 wrap to zero", cur_line_o, 0);
    chk("R4 last held line", hold_line_o, 7);
    // R9 hold stays between boundaries
    for (int i = 0; i < 3; i++) step(0, 1, 0, 8'h01, 0);
    chk("R9 held line kept", hold_line_o, 7);
    chk("R9 held count kept", hold_cnt_o, 0);

    // R8: clear wins over frame
    step(1, 1, 1, 8'hFF, 0);
    chk("R8 clear line", cur_line_o, 0);
    chk("R8 clear held count", hold_cnt_o, 0);
    chk("R8 clear held line", hold_line_o, 0);
    step(0, 1, 1, 8'h00, 0);
    chk("R8 running count zeroed", hold_cnt_o, 0);
    chk("R8 line after clear", hold_line_o, 0);

    // R5: saturation on line 1
    for (int i = 0; i < 66000; i++) step(0, 1, 0, 8'h02, 0);
    step(0, 1, 1, 8'h00, 0);
    chk("R5 saturated count", hold_cnt_o, 65535);
    chk("R5 line index", hold_line_o, 1);

    // Random run against bench model, state now synced
    for (int i = 0; i < 4000; i++) begin
      logic c, m, f;
      logic [7:0] e;
      c = ($urandom_range(499) == 0);
      m = ($urandom_range(9) != 0);
      f = ($urandom_range(29) == 0);
      e = 8'($urandom) & 8'($urandom);
      step(c, m, f, e, 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule